// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a two-wire serial target that gives a bus host access to a small byte-wide register file. It samples the clock and data lines with the system clock and detects start, repeated-start and stop conditions. It drives the data line open-drain through a single output-enable: high means pull low, low means release. Each transfer begins with the target's 7-bit address. A write then carries a start index and a byte count, followed by data bytes that land at consecutive indices.

A read reuses the index set by a preceding write phase. That write phase carries the address and an index byte and is followed by a repeated start and the address with the read bit. The target first returns the count value held in the dedicated count register (index 8), then streams register contents from the index onward for as long as the host acknowledges. The index wraps modulo the register-file depth. A host not-acknowledge ends the data stream.

Top module: `smb_idx_target`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` = 0) and every register entry, including the count register at index 8, reads back as 0x00.
- R2: A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. A stop at any point, including in the middle of a byte, returns the target to idle with SDA released and writes nothing for the unfinished byte.
- R3: When the address bits [7:1] of the first byte after a start differ from the target address, the target does not acknowledge that byte. It then drives nothing and changes no register until the next start or stop.
- R4: A write runs start, address with bit 0 = 0, index N, count X, data bytes, stop. The target acknowledges (pulls SDA low during the ninth clock) each of these bytes, and data byte k is stored at index (N+k) mod 16.
- R5: Data bytes beyond the X-th in a write are still acknowledged but are discarded.
- R6: If a write stops after fewer than X data bytes, the bytes already received stay stored and the remaining entries keep their values.
- R7: The index wraps modulo the depth (16): the index byte is taken modulo 16, and writes or reads continuing past entry 15 continue at entry 0.
- R8: After a repeated start and the address with bit 0 = 1, the first byte the target sends is the content of the count register at index 8. Data bytes from index N onward follow it, MSB first.
- R9: When the host answers a byte with a not-acknowledge (SDA high in the ninth clock), the target releases SDA, drives no further bits, and answers correctly to the next start.
- R10: The target changes its SDA drive only while SCL is low, and releases SDA after the acknowledge clock pulse.
- R11: The index received in the write phase is kept across the repeated start and is used as the first data index of the read phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the bus lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Data-line pull-down enable (1 drives SDA low) |

## Verification
In one cycle the register write of a data byte and the wrap of the index from 15 back to 0 both happen, when the byte being stored lands in the top entry. The bench provokes this by starting writes at index 15 through an index byte of 0x1F, so that the index-byte truncation and the wrap are exercised together. It then reads back a window across entries 13 to 2. The check is that the bytes sit at 15, 0 and 1 and that the neighbouring entries still hold their old values. The same coincidence on the read side is judged by a read that starts at index 14 and runs past the top of the file.

// File: rtl/smb_idx_pkg.sv
`timescale 1ns/1ps
package smb_idx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_ACK,
    ST_TX,
    ST_TX_END,
    ST_HACK,
    ST_TX_NEXT,
    ST_IGNORE
  } state_e;

  // which byte of a write transfer is being received
  typedef enum logic [1:0] {
    PH_ADDR,
    PH_IDX,
    PH_CNT,
    PH_DATA
  } phase_e;

endpackage

// File: rtl/smb_line_cond.sv
`timescale 1ns/1ps
module smb_line_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sync_q, sda_sync_q;
  logic              scl_last_q, sda_last_q;

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_last_q <= 1'b1;
      sda_last_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[STAGES-2:0], sda_i};
      scl_last_q <= scl_sync_q[STAGES-1];
      sda_last_q <= sda_sync_q[STAGES-1];
    end
  end

  assign scl_o      = scl_sync_q[STAGES-1];
  assign sda_o      = sda_sync_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_last_q;
  assign scl_fall_o = ~scl_o & scl_last_q;
  // SCL must be high in both samples around the data edge
  assign start_o    = scl_o & scl_last_q & sda_last_q & ~sda_o;
  assign stop_o     = scl_o & scl_last_q & ~sda_last_q & sda_o;

endmodule

// File: rtl/smb_idx_regfile.sv
`timescale 1ns/1ps
module smb_idx_regfile #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned CNT_IDX = 8,
  parameter int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    cnt_o
);

  localparam logic [IDX_W-1:0] CNT_SEL = IDX_W'(CNT_IDX);

  logic [DEPTH-1:0][DW-1:0] mem_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (we_i && (widx_i == IDX_W'(g))) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[ridx_i];
  assign cnt_o   = mem_q[CNT_SEL];

endmodule

// File: rtl/smb_idx_target.sv
`timescale 1ns/1ps
module smb_idx_target
  import smb_idx_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h52,
  parameter int unsigned DEPTH       = 16,   // power of two
  parameter int unsigned CNT_IDX     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned DW    = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  smb_line_cond #(
    .STAGES(SYNC_STAGES)
  ) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  state_e           state_q;
  phase_e           phase_q;
  logic [2:0]       bit_cnt_q;
  logic [DW-1:0]    shreg_q, tx_q, remain_q;
  logic [IDX_W-1:0] idx_q;
  logic             rd_mode_q, ack_q, oe_q;

  logic [DW-1:0]    rx_byte, rd_data, cnt_byte;
  logic             reg_we;

  assign rx_byte = {shreg_q[DW-2:0], sda_s};
  assign reg_we  = (state_q == ST_RX) && scl_rise && (bit_cnt_q == 3'd7) &&
                   (phase_q == PH_DATA) && (remain_q != '0);

  smb_idx_regfile #(
    .DEPTH  (DEPTH),
    .DW     (DW),
    .CNT_IDX(CNT_IDX),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .widx_i (idx_q),
    .wdata_i(rx_byte),
    .ridx_i (idx_q),
    .rdata_o(rd_data),
    .cnt_o  (cnt_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      remain_q  <= '0;
      idx_q     <= '0;
      rd_mode_q <= 1'b0;
      ack_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start) begin
      state_q   <= ST_RX;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      rd_mode_q <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      rd_mode_q <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_q   <= rx_byte;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              state_q <= ST_RX_END;
              ack_q   <= 1'b1;
              case (phase_q)
                PH_ADDR: begin
                  if (rx_byte[7:1] == DEV_ADDR) begin
                    rd_mode_q <= rx_byte[0];
                    phase_q   <= PH_IDX;
                  end else begin
                    ack_q <= 1'b0;
                  end
                end
                PH_IDX: begin
                  idx_q   <= rx_byte[IDX_W-1:0];
                  phase_q <= PH_CNT;
                end
                PH_CNT: begin
                  remain_q <= rx_byte;
                  phase_q  <= PH_DATA;
                end
                default: begin
                  // surplus bytes: acknowledged, not stored
                  if (remain_q != '0) begin
                    remain_q <= remain_q - 8'd1;
                    idx_q    <= idx_q + 1'b1;
                  end
                end
              endcase
            end
          end
        end
        ST_RX_END: begin
          if (scl_fall) begin
            if (ack_q) begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rd_mode_q) begin
              tx_q    <= cnt_byte;
              oe_q    <= ~cnt_byte[DW-1];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) state_q <= ST_TX_END;
          end else if (scl_fall) begin
            tx_q <= {tx_q[DW-2:0], 1'b0};
            oe_q <= ~tx_q[DW-2];
          end
        end
        ST_TX_END: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            state_q <= ST_HACK;
          end
        end
        ST_HACK: begin
          if (scl_rise) state_q <= sda_s ? ST_IGNORE : ST_TX_NEXT;
        end
        ST_TX_NEXT: begin
          if (scl_fall) begin
            tx_q      <= rd_data;
            oe_q      <= ~rd_data[DW-1];
            idx_q     <= idx_q + 1'b1;
            bit_cnt_q <= '0;
            state_q   <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  // R10: drive changes only follow an SCL low sample
  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(oe_q) && !$past(start || stop)) |-> !$past(scl_s));

  p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (state_q == ST_IDLE) && !oe_q);

  p_start_rx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == ST_RX) && (bit_cnt_q == 3'd0) && (phase_q == PH_ADDR));

  p_ignore_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !oe_q);

  p_ack_driven_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK) |-> oe_q);

  p_we_budget_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |=> (remain_q == $past(remain_q) - 8'd1));

  p_idx_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |=> (idx_q == $past(idx_q) + 1'b1));

  p_host_ack_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HACK) |-> !oe_q);

endmodule

// File: tb/smb_idx_target_bench.sv
`timescale 1ns/1ps
module smb_idx_target_bench;

  localparam int DEPTH = 16;
  localparam int Q     = 20;
  localparam logic [7:0] WR_ADDR  = 8'hA4;
  localparam logic [7:0] RD_ADDR  = 8'hA5;
  localparam logic [7:0] BAD_ADDR = 8'hA6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_pull = 1'b0;
  logic oe;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_m [DEPTH];
  logic [7:0] wbuf [32];

  logic oe_last = 1'b0;
  int   r10_bad = 0;
  bit   ign_win = 1'b0;
  int   ign_oe  = 0;

  always #2.5 clk = ~clk;

  assign sda_line = ~(oe | host_pull);

  smb_idx_target u_smb_idx_target (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .sda_oe_o(oe)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (oe !== oe_last && scl) r10_bad++;
      if (ign_win && oe) ign_oe++;
    end
    oe_last = oe;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp_v);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic half_q();
    repeat (Q/2) @(posedge clk);
    #1;
  endtask

  task automatic start_cond();
    host_pull = 1'b0; wait_q();
    scl = 1'b1;       wait_q();
    host_pull = 1'b1; wait_q();
    scl = 1'b0;       wait_q();
  endtask

  task automatic stop_cond();
    host_pull = 1'b1; wait_q();
    scl = 1'b1;       wait_q();
    host_pull = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      host_pull = ~b[i]; wait_q();
      scl = 1'b1;        wait_q();
      scl = 1'b0;
    end
    host_pull = 1'b0; wait_q();
    scl = 1'b1; half_q();
    acked = ~sda_line;
    half_q();
    scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack_it);
    host_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      scl = 1'b1; half_q();
      b[i] = sda_line;
      half_q();
      scl = 1'b0;
    end
    host_pull = ack_it; wait_q();
    scl = 1'b1; wait_q();
    scl = 1'b0;
    host_pull = 1'b0;
  endtask

  task automatic wr(input logic [7:0] n, input logic [7:0] x, input int nb);
    logic a;
    start_cond();
    send_byte(WR_ADDR, a); chk("R4 address ack", {7'd0, a}, 8'd1);
    send_byte(n, a);       chk("R4 index ack", {7'd0, a}, 8'd1);
    send_byte(x, a);       chk("R4 count ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < nb; k++) begin
      send_byte(wbuf[k], a);
      chk(k < int'(x) ? "R4 data ack" : "R5 surplus ack", {7'd0, a}, 8'd1);
      if (k < int'(x)) exp_m[(int'(n) + k) % DEPTH] = wbuf[k];
    end
    stop_cond();
  endtask

  task automatic rd(input logic [7:0] n, input int nb, input string tag);
    logic a;
    logic [7:0] b;
    start_cond();
    send_byte(WR_ADDR, a); chk("R8 write address ack", {7'd0, a}, 8'd1);
    send_byte(n, a);       chk("R11 index ack", {7'd0, a}, 8'd1);
    start_cond();
    send_byte(RD_ADDR, a); chk("R8 read address ack", {7'd0, a}, 8'd1);
    recv_byte(b, nb > 0);  chk("R8 count byte", b, exp_m[8]);
    for (int k = 0; k < nb; k++) begin
      recv_byte(b, k < nb - 1);
      chk(tag, b, exp_m[(int'(n) + k) % DEPTH]);
    end
    stop_cond();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    for (int i = 0; i < DEPTH; i++) exp_m[i] = 8'h00;
    repeat (10) @(posedge clk);
    #1;
    chk("R1 released in reset", {7'd0, oe}, 8'd0);
    rst_n = 1'b1;
    wait_q();
    chk("R1 released after reset", {7'd0, oe}, 8'd0);

    rd(8'd0, DEPTH, "R1 reset contents");

    // full sweep of the file
    for (int i = 0; i < DEPTH; i++) wbuf[i] = 8'((i * 29 + 3) & 8'hFF);
    wr(8'd0, 8'd16, DEPTH);
    rd(8'd0, DEPTH, "R4 stored byte");
    rd(8'd5, 4, "R11 index kept across restart");
    rd(8'd14, 4, "R7 read past top entry");

    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
    wr(8'd3, 8'd2, 4);
    rd(8'd2, 4, "R5 surplus bytes discarded");

    wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
    wr(8'd10, 8'd5, 2);
    rd(8'd9, 6, "R6 partial write kept");

    // index byte 0x1F truncates to 15, then wraps
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
    wr(8'h1F, 8'd3, 3);
    rd(8'd13, 6, "R7 write wraps to entry 0");

    wbuf[0] = 8'h03;
    wr(8'd8, 8'd1, 1);
    rd(8'd0, 3, "R8 data after count byte");

    // foreign address
    ign_oe = 0;
    ign_win = 1'b1;
    start_cond();
    send_byte(BAD_ADDR, a); chk("R3 foreign address not acked", {7'd0, a}, 8'd0);
    send_byte(8'h00, a);    chk("R3 index ignored", {7'd0, a}, 8'd0);
    send_byte(8'h01, a);    chk("R3 count ignored", {7'd0, a}, 8'd0);
    send_byte(8'h5A, a);    chk("R3 data ignored", {7'd0, a}, 8'd0);
    ign_win = 1'b0;
    chk("R3 no drive while ignoring", 8'(ign_oe), 8'd0);
    rd(8'd0, 2, "R3 registers untouched");

    // host not-acknowledge on the count byte
    start_cond();
    send_byte(WR_ADDR, a);
    send_byte(8'd4, a);
    start_cond();
    send_byte(RD_ADDR, a);  chk("R9 read address ack", {7'd0, a}, 8'd1);
    recv_byte(b, 1'b0);     chk("R9 count before nack", b, exp_m[8]);
    wait_q();
    chk("R9 released after nack", {7'd0, oe}, 8'd0);
    recv_byte(b, 1'b0);     chk("R9 silent after nack", b, 8'hFF);
    rd(8'd4, 2, "R9 restart after nack");

    // stop in the middle of a data byte
    start_cond();
    send_byte(WR_ADDR, a);
    send_byte(8'd2, a);
    send_byte(8'd1, a);
    for (int i = 0; i < 4; i++) begin
      host_pull = 1'b1; wait_q();
      scl = 1'b1;       wait_q();
      scl = 1'b0;
    end
    stop_cond();
    wait_q();
    chk("R2 idle after stop", {7'd0, oe}, 8'd0);
    rd(8'd2, 1, "R2 aborted byte not stored");

    chk("R10 SDA drive changed only with SCL low", 8'(r10_bad), 8'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule